// File: doc/BRIEF.md
# Set/Clear Peripheral Clock Gate Controller

This block controls the enables of up to 64 peripheral clocks, arranged as groups of 32. Software never has to read, modify and write a shared enable word. Each group has a set port, where a 1 bit turns that clock on, and a clear port, where a 1 bit turns that clock off. Every 0 bit in such a write leaves its clock alone. Two clients can therefore change different clocks without any locking.

Each group also offers two read ports:
- a request word, which shows what software last asked for;
- a status word, which shows the state the gates have actually reached.

Status trails request by a fixed settling delay. Software that has just switched a clock polls the status bit until it matches the request.

The registered status bits drive the `clk_en_o` outputs. They also drive one glitch-free gate per clock, which produces the gated clocks on `gclk_o`. A clock with identifier N sits in group N/32 at bit N%32, and appears on output index N.

Top module: `pgc_top`

## Requirements
- R1: Writing a word to a group's set port (byte offset 0x24 for group 0, 0x34 for group 1) sets the request bit of each clock whose data bit is 1. The new request value is visible from the cycle after the write.
- R2: Writing a word to a group's clear port (0x28 for group 0, 0x38 for group 1) clears the request bit of each clock whose data bit is 1.
- R3: The request word reads at 0x2C (group 0) and 0x3C (group 1). The status word reads at 0x30 (group 0) and 0x40 (group 1). Clock N maps to group 1 when N > 31, otherwise to group 0, at bit N % 32, and drives `clk_en_o[N]` and `gclk_o[N]`.
- R4: A status bit equals its request bit delayed by exactly 3 clock cycles. After a write at rising edge E, `clk_en_o` shows the new value from edge E+3. The request readback already shows it from edge E.
- R5: After reset, every request bit, every status bit and every `clk_en_o` bit is 1, and `rdata_o` is 0.
- R6: Data bits that are 0 in a set or clear write have no effect. Writes to the request offsets, the status offsets or any unmapped offset change nothing.
- R7: A read returns its data on `rdata_o` from the clock edge that accepts it. `rdata_o` holds that value until the next read. Reads of a set port, a clear port or an unmapped or unaligned offset return 0.
- R8: `gclk_o[N]` is low whenever `clk` is low. During each high phase of `clk`, `gclk_o[N]` equals the value `clk_en_o[N]` held just before the rising edge that began that phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| rd_en_i | input | 1 | Read strobe, one word per cycle |
| addr_i | input | 8 | Byte offset of the accessed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| clk_en_o | output | 64 | Settled enable of each clock, index = clock identifier |
| gclk_o | output | 64 | Gated copy of `clk` for each clock |

## Verification
Directed sequences cover the following:
- clearing and setting a single clock in group 0;
- switching a single clock in group 1, which shows that identifier 40 lands on group 1 bit 8;
- all-zero writes and writes to the read-only offsets, which must leave every bit unchanged.

Polling one status bit edge by edge after a clear shows whether the lag is exactly three cycles rather than two or four.

A long stretch of random, sparse set and clear words is then mixed with random reads, including unmapped offsets and reads issued in the same cycle as writes. This stretch is compared each cycle against a bench model of request, status and read data. It separates bit-local updates from whole-word overwrites, and it separates group selection from offset decoding.

The gated clocks are checked in both clock phases against the enable held before each rising edge.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // Width of one gate group, which is also the bus data width
  localparam int GROUP_W = 32;

  // First word of the register window and the stride between groups
  localparam logic [7:0] WIN_BASE   = 8'h24;
  localparam int         GRP_STRIDE = 16;

  // Word position inside a group's four-word block
  typedef enum logic [1:0] {
    REG_SET  = 2'd0,
    REG_CLR  = 2'd1,
    REG_REQ  = 2'd2,
    REG_STAT = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/pgc_decode.sv
module pgc_decode
  import pgc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 2,
  localparam int GRP_W     = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [GRP_W-1:0]  grp_o,
  output reg_kind_e         kind_o
);

  logic [ADDR_W-1:0] rel;
  logic              above_base;
  logic              aligned;
  logic              grp_ok;

  always_comb begin
    rel        = addr_i - ADDR_W'(WIN_BASE);
    above_base = (addr_i >= ADDR_W'(WIN_BASE));
    aligned    = (rel[1:0] == 2'b00);
    grp_o      = rel[ADDR_W-1:4];
    kind_o     = reg_kind_e'(rel[3:2]);
    grp_ok     = (int'(grp_o) < NUM_GROUPS);
    hit_o      = above_base && aligned && grp_ok;
  end

endmodule

// File: rtl/pgc_group.sv
module pgc_group #(
  parameter int GW     = 32,
  parameter int SETTLE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] set_i,
  input  logic [GW-1:0] clr_i,
  output logic [GW-1:0] req_o,
  output logic [GW-1:0] stat_o
);

  logic [GW-1:0] req_q;
  logic [GW-1:0] req_d;
  logic [GW-1:0] lag_q [SETTLE];

  // Clear outranks set on a shared bit; zero bits keep their value
  always_comb req_d = (req_q | set_i) & ~clr_i;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '1;
    else     req_q <= req_d;
  end

  generate
    for (genvar s = 0; s < SETTLE; s++) begin : g_lag
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) lag_q[s] <= '1;
          else     lag_q[s] <= req_q;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (rst) lag_q[s] <= '1;
          else     lag_q[s] <= lag_q[s-1];
        end
      end
    end
  endgenerate

  assign req_o  = req_q;
  assign stat_o = lag_q[SETTLE-1];

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|(set_i & ~clr_i)) |=> ((req_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i))); // R1

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (|clr_i) |=> ((req_q & $past(clr_i)) == '0)); // R2

  AST_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((req_q ^ $past(req_q)) & ~$past(set_i | clr_i)) == '0)); // R6

endmodule

// File: rtl/pgc_clk_gate.sv
module pgc_clk_gate (
  input  logic clk,
  input  logic en_i,
  output logic gclk_o
);

  logic en_held;

  // Transparent only while the clock is low, so the AND never glitches
  always_latch begin
    if (!clk) en_held = en_i;
  end

  assign gclk_o = clk & en_held;

endmodule

// File: rtl/pgc_top.sv
module pgc_top
  import pgc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_GROUPS = 2,
  parameter int SETTLE     = 3,
  localparam int NCLK      = NUM_GROUPS * GROUP_W,
  localparam int GRP_W     = ADDR_W - 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [GROUP_W-1:0] wdata_i,
  output logic [GROUP_W-1:0] rdata_o,
  output logic [NCLK-1:0]    clk_en_o,
  output logic [NCLK-1:0]    gclk_o
);

  logic             dec_hit;
  logic [GRP_W-1:0] dec_grp;
  reg_kind_e        dec_kind;

  logic [GROUP_W-1:0] req_w  [NUM_GROUPS];
  logic [GROUP_W-1:0] stat_w [NUM_GROUPS];
  logic [GROUP_W-1:0] rd_val;
  logic [GROUP_W-1:0] rdata_q;

  pgc_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_decode (
    .addr_i (addr_i),
    .hit_o  (dec_hit),
    .grp_o  (dec_grp),
    .kind_o (dec_kind)
  );

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic               sel;
      logic [GROUP_W-1:0] set_v;
      logic [GROUP_W-1:0] clr_v;

      always_comb begin
        sel   = wr_en_i && dec_hit && (dec_grp == GRP_W'(g));
        set_v = (sel && dec_kind == REG_SET) ? wdata_i : '0;
        clr_v = (sel && dec_kind == REG_CLR) ? wdata_i : '0;
      end

      pgc_group #(
        .GW     (GROUP_W),
        .SETTLE (SETTLE)
      ) u_group (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .req_o  (req_w[g]),
        .stat_o (stat_w[g])
      );

      assign clk_en_o[g*GROUP_W +: GROUP_W] = stat_w[g];
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (dec_hit && dec_grp == GRP_W'(g)) begin
        if (dec_kind == REG_REQ)  rd_val = req_w[g];
        if (dec_kind == REG_STAT) rd_val = stat_w[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  generate
    for (genvar n = 0; n < NCLK; n++) begin : g_gate
      pgc_clk_gate u_gate (
        .clk    (clk),
        .en_i   (clk_en_o[n]),
        .gclk_o (gclk_o[n])
      );
    end
  endgenerate

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && dec_hit && (dec_kind == REG_SET || dec_kind == REG_CLR)) |=> (rdata_o == '0)); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !dec_hit) |=> (rdata_o == '0)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o)); // R7

endmodule

// File: tb/pgc_top_tb.sv
`timescale 1ns/1ps
module pgc_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] clk_en;
  logic [63:0] gclk;

  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit run_g = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pgc_top u_dut (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr),
    .rd_en_i  (rd),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .clk_en_o (clk_en),
    .gclk_o   (gclk)
  );

  // Bench model from the requirements
  logic [63:0] m_req, m_d1, m_d2, m_st;
  logic [31:0] m_rd;

  function automatic logic [31:0] read_model(input logic [7:0] a);
    case (a)
      8'h2C:   return m_req[31:0];
      8'h30:   return m_st[31:0];
      8'h3C:   return m_req[63:32];
      8'h40:   return m_st[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req <= '1; m_d1 <= '1; m_d2 <= '1; m_st <= '1; m_rd <= '0;
    end else begin
      if (wr) begin
        case (addr)
          8'h24: m_req[31:0]  <= m_req[31:0]  | wdata;
          8'h28: m_req[31:0]  <= m_req[31:0]  & ~wdata;
          8'h34: m_req[63:32] <= m_req[63:32] | wdata;
          8'h38: m_req[63:32] <= m_req[63:32] & ~wdata;
          default: ;
        endcase
      end
      m_d1 <= m_req; m_d2 <= m_d1; m_st <= m_d2;
      if (rd) m_rd <= read_model(addr);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [63:0] en_hold;

  always @(negedge clk) begin
    if (run && !done) begin
      chk(clk_en == m_st, "R4 status lag", clk_en, m_st);
      chk(rdata == m_rd, "R3 read data", {32'h0, rdata}, {32'h0, m_rd});
      #1 chk(gclk == '0, "R8 low phase", gclk, 64'h0);
      en_hold = clk_en;
      run_g = 1;
    end
  end

  always @(posedge clk) begin
    if (run_g && !done) begin
      #1 chk(gclk == en_hold, "R8 high phase", gclk, en_hold);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  logic [31:0] rv;

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    run = 1;
    // R5 reset state
    chk(clk_en == '1, "R5 status after reset", clk_en, '1);
    chk(rdata == '0, "R5 rdata after reset", {32'h0, rdata}, 64'h0);
    bus_read(8'h3C, rv);
    chk(rv == '1, "R5 request after reset", {32'h0, rv}, {32'h0, 32'hFFFFFFFF});

    // R2 + R4: clear clock 5, poll the lag
    bus_write(8'h28, 32'h20);
    chk(clk_en[5] == 1'b1, "R4 lag edge1", {63'h0, clk_en[5]}, 64'h1);
    @(negedge clk); chk(clk_en[5] == 1'b1, "R4 lag edge2", {63'h0, clk_en[5]}, 64'h1);
    @(negedge clk); chk(clk_en[5] == 1'b1, "R4 lag edge3", {63'h0, clk_en[5]}, 64'h1);
    @(negedge clk); chk(clk_en[5] == 1'b0, "R4 lag edge4", {63'h0, clk_en[5]}, 64'h0);
    bus_read(8'h2C, rv);
    chk(rv == 32'hFFFFFFDF, "R2 clear one bit", {32'h0, rv}, {32'h0, 32'hFFFFFFDF});

    // R1: set it back
    bus_write(8'h24, 32'h20);
    bus_read(8'h2C, rv);
    chk(rv == '1, "R1 set one bit", {32'h0, rv}, {32'h0, 32'hFFFFFFFF});

    // R3: clock 40 lives in group 1 bit 8
    bus_write(8'h38, 32'h100);
    repeat (4) @(negedge clk);
    chk(clk_en == ~(64'h1 << 40), "R3 id 40 mapping", clk_en, ~(64'h1 << 40));
    bus_read(8'h40, rv);
    chk(rv == 32'hFFFFFEFF, "R3 group1 status", {32'h0, rv}, {32'h0, 32'hFFFFFEFF});

    // R6: zero writes and read-only offsets
    bus_write(8'h28, 32'h0);
    bus_write(8'h2C, 32'h0);
    bus_write(8'h30, 32'h0);
    bus_write(8'h40, 32'h0);
    bus_write(8'h00, 32'hFFFFFFFF);
    bus_read(8'h2C, rv);
    chk(rv == '1, "R6 ignored writes g0", {32'h0, rv}, {32'h0, 32'hFFFFFFFF});
    bus_read(8'h3C, rv);
    chk(rv == 32'hFFFFFEFF, "R6 ignored writes g1", {32'h0, rv}, {32'h0, 32'hFFFFFEFF});

    // R7: write-only and unmapped reads give zero
    bus_read(8'h24, rv);
    chk(rv == '0, "R7 read set port", {32'h0, rv}, 64'h0);
    bus_read(8'h38, rv);
    chk(rv == '0, "R7 read clear port", {32'h0, rv}, 64'h0);
    bus_read(8'h2E, rv);
    chk(rv == '0, "R7 unaligned read", {32'h0, rv}, 64'h0);

    // Random mix
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      wr = ($urandom % 3) != 0;
      rd = ($urandom % 2) != 0;
      case ($urandom % 10)
        0: addr = 8'h24; 1: addr = 8'h28; 2: addr = 8'h2C; 3: addr = 8'h30;
        4: addr = 8'h34; 5: addr = 8'h38; 6: addr = 8'h3C; 7: addr = 8'h40;
        8: addr = 8'h44; default: addr = 8'h10;
      endcase
      wdata = $urandom & $urandom & $urandom;
    end
    @(negedge clk); wr = 0; rd = 0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule